// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block guards a system against firmware that stops running. Once armed, a 12-bit down-counter advances on a slow tick that arrives as a clock enable from a separate low-speed oscillator, so a stalled main clock tree does not stop the countdown. A power-of-two prescaler sits between the tick and the counter. When the counter is already at zero and another prescaled tick arrives, the block raises a one-cycle system-reset request. A sticky cause flag records that event, and it survives the system reset that follows.

Software controls the block through a small write port with four targets: a key register, a prescaler register, a reload register and a control register. Each 16-bit key value means one action. One value arms the watchdog, and nothing but a system reset disarms it. Another value refreshes the counter. A third value opens the two configuration registers for writing. A debug freeze input pauses the countdown while the core is halted. Configuration changes made while the watchdog runs are held pending, with a busy indication, until the next low-speed tick.

Top module: `keyed_watchdog`

## Requirements
- R1: Writing key 16'hCCCC to target 0 sets `running`. While `rst` is low no write clears `running`, including other key values. Asserting `rst` clears it.
- R2: While running, the counter decrements once for every P low-speed ticks. The reset request is seen P·(RL+1) ticks after the start or refresh write, and it is visible in the clock cycle after the tick that expires the counter. P is the divide ratio and RL is the active reload value.
- R3: `wdg_reset_req` is high for exactly one clock cycle at each expiry. After an expiry the counter reloads and keeps running. The request is never raised while the block is not running.
- R4: Writing key 16'hAAAA to target 0 reloads the counter with the active reload value and restarts the prescaler from zero.
- R5: The prescaler field is wr_data[2:0] at target 1. Codes 0 to 6 select divide-by 4, 8, 16, 32, 64, 128 and 256, and code 7 also selects 256. The reload value is wr_data[11:0] at target 2. After `rst` the code is 0 and the reload is 4095.
- R6: Key 16'h5555 opens targets 1 and 2 for writing. Any other key write closes them, and so does `rst`. Writes to a closed target are ignored.
- R7: An open write to target 1 or 2 while stopped takes effect at once, and `pr_busy`/`rl_busy` stay low. The same write while running sets the matching busy flag. The new value becomes active at the next low-speed tick, and the busy flag then clears.
- R8: While `dbg_freeze_en` and `core_halted` are both high, low-speed ticks neither advance the prescaler nor the counter. A halt with the freeze enable low has no effect.
- R9: `wdg_reset_flag` rises together with the reset request and is unaffected by `rst`. It clears only when `por` is asserted or a write to target 3 has wr_data[0]=1. If a set and a clear fall in the same cycle, the set wins.
- R10: If a refresh key write falls in the same clock cycle as the tick that would expire the counter, the refresh wins. No request is raised, and the next timeout is counted from that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high system reset |
| por | input | 1 | Power-on reset, clears only the cause flag |
| lsi_tick | input | 1 | One-cycle enable per low-speed oscillator period |
| dbg_freeze_en | input | 1 | Allows a core halt to freeze the countdown |
| core_halted | input | 1 | Core is halted by a debugger |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Target: 0 key, 1 prescaler, 2 reload, 3 control |
| wr_data | input | 16 | Write data |
| running | output | 1 | Watchdog armed |
| pr_busy | output | 1 | Prescaler update pending |
| rl_busy | output | 1 | Reload update pending |
| wdg_reset_req | output | 1 | One-cycle system reset request |
| wdg_reset_flag | output | 1 | Sticky watchdog reset cause |

## Verification
Two events can land in the same cycle: a refresh key write, and the final low-speed tick that would expire the counter. The bench drives the tick enable and the refresh write on the same clock edge, at exactly the tick number the timeout formula predicts for expiry. The refresh is judged correct if the scoreboard sees no request at that tick and the next request arrives one full timeout later, counted from the collision tick. A pending-configuration write coinciding with the applying tick is covered by the same ordering rule. Busy-flag clearing and timeout length after the update confirm it.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    localparam int CNT_W     = 12;
    localparam int KEY_W     = 16;
    localparam int PR_W      = 3;
    localparam int DIV_W     = 8;
    localparam int SHIFT_MIN = 2;

    localparam logic [KEY_W-1:0] KEY_ARM  = 16'hCCCC;
    localparam logic [KEY_W-1:0] KEY_FEED = 16'hAAAA;
    localparam logic [KEY_W-1:0] KEY_OPEN = 16'h5555;

    typedef enum logic [1:0] {
        SEL_KEY    = 2'd0,
        SEL_PRESC  = 2'd1,
        SEL_RELOAD = 2'd2,
        SEL_CTRL   = 2'd3
    } wsel_e;

    typedef struct packed {
        logic arm;
        logic feed;
        logic open;
    } key_cmd_t;

    typedef struct packed {
        logic [PR_W-1:0]  presc;
        logic [CNT_W-1:0] reload;
    } wdg_cfg_t;

    function automatic key_cmd_t decode_key(input logic [KEY_W-1:0] k);
        key_cmd_t c;
        c.arm  = (k == KEY_ARM);
        c.feed = (k == KEY_FEED);
        c.open = (k == KEY_OPEN);
        return c;
    endfunction

    function automatic logic [DIV_W-1:0] div_limit(input logic [PR_W-1:0] code);
        int sh;
        logic [DIV_W:0] one;
        sh = int'(code) + SHIFT_MIN;
        if (sh > DIV_W) sh = DIV_W;
        one = 1;
        return DIV_W'((one << sh) - 1'b1);
    endfunction
endpackage

// File: rtl/wdg_keyregs.sv
module wdg_keyregs
    import wdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [KEY_W-1:0] wr_data,
    input  logic             lsi_tick,
    output logic             running,
    output logic             load,
    output logic             clr_flag,
    output wdg_cfg_t         cfg,
    output logic             pr_busy,
    output logic             rl_busy
);
    key_cmd_t cmd;
    logic     key_wr, pr_wr, rl_wr, open_q;
    wdg_cfg_t act_q, shadow_q;

    assign key_wr   = wr_en && (wr_sel == SEL_KEY);
    assign cmd      = key_wr ? decode_key(wr_data) : '0;
    assign pr_wr    = wr_en && (wr_sel == SEL_PRESC)  && open_q;
    assign rl_wr    = wr_en && (wr_sel == SEL_RELOAD) && open_q;
    assign clr_flag = wr_en && (wr_sel == SEL_CTRL)   && wr_data[0];
    assign load     = cmd.arm || cmd.feed;

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            open_q  <= 1'b0;
        end else begin
            if (cmd.arm) running <= 1'b1;
            if (key_wr)  open_q  <= cmd.open;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q.presc     <= '0;
            act_q.reload    <= '1;
            shadow_q.presc  <= '0;
            shadow_q.reload <= '1;
            pr_busy         <= 1'b0;
            rl_busy         <= 1'b0;
        end else begin
            if (lsi_tick && pr_busy) begin
                act_q.presc <= shadow_q.presc;
                pr_busy     <= 1'b0;
            end
            if (lsi_tick && rl_busy) begin
                act_q.reload <= shadow_q.reload;
                rl_busy      <= 1'b0;
            end
            if (pr_wr) begin
                if (running) begin
                    shadow_q.presc <= wr_data[PR_W-1:0];
                    pr_busy        <= 1'b1;
                end else begin
                    act_q.presc    <= wr_data[PR_W-1:0];
                end
            end
            if (rl_wr) begin
                if (running) begin
                    shadow_q.reload <= wr_data[CNT_W-1:0];
                    rl_busy         <= 1'b1;
                end else begin
                    act_q.reload    <= wr_data[CNT_W-1:0];
                end
            end
        end
    end

    assign cfg = act_q;

    // R1: once armed, only rst disarms
    a_r1_stays_running: assert property (@(posedge clk) disable iff (rst)
        running |=> running);
    // R6: a closed target keeps its active value
    a_r6_closed_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_RELOAD && !open_q && !rl_busy) |=> $stable(act_q.reload));
    // R7: a pending update is applied by the next tick
    a_r7_busy_clears: assert property (@(posedge clk) disable iff (rst)
        (rl_busy && lsi_tick && !rl_wr) |=> !rl_busy);
endmodule

// File: rtl/wdg_divider.sv
module wdg_divider
    import wdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             clear,
    input  logic [PR_W-1:0]  code,
    output logic             stick
);
    logic [DIV_W-1:0] div_q, lim;
    logic             wrap;

    assign lim   = div_limit(code);
    assign wrap  = (div_q >= lim);
    assign stick = tick_en && wrap && !clear;

    always_ff @(posedge clk) begin
        if (rst || clear) div_q <= '0;
        else if (tick_en) div_q <= wrap ? '0 : div_q + 1'b1;
    end

    // R8: without an enabled tick the divider holds
    a_r8_div_holds: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !clear) |=> $stable(div_q));
endmodule

// File: rtl/wdg_downcounter.sv
module wdg_downcounter
    import wdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             stick,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cnt,
    output logic             expire_now,
    output logic             req
);
    assign expire_now = stick && (cnt == '0) && !load;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '1;
            req <= 1'b0;
        end else begin
            req <= expire_now;
            if (load)       cnt <= reload;
            else if (stick) cnt <= (cnt == '0) ? reload : cnt - 1'b1;
        end
    end

    // R3: request lasts one cycle
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
        req |=> !req);
    // R2: a request follows a zero count
    a_r2_from_zero: assert property (@(posedge clk) disable iff (rst)
        $rose(req) |-> $past(cnt) == '0);
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import wdg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        por,
    input  logic        lsi_tick,
    input  logic        dbg_freeze_en,
    input  logic        core_halted,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [15:0] wr_data,
    output logic        running,
    output logic        pr_busy,
    output logic        rl_busy,
    output logic        wdg_reset_req,
    output logic        wdg_reset_flag
);
    wdg_cfg_t         cfg;
    logic             load, clr_flag, frozen, tick_en, stick, expire_now;
    logic [CNT_W-1:0] cnt;

    wdg_keyregs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data[KEY_W-1:0]), .lsi_tick(lsi_tick),
        .running(running), .load(load), .clr_flag(clr_flag), .cfg(cfg),
        .pr_busy(pr_busy), .rl_busy(rl_busy)
    );

    assign frozen  = dbg_freeze_en && core_halted;
    assign tick_en = lsi_tick && running && !frozen;

    wdg_divider u_div (
        .clk(clk), .rst(rst), .tick_en(tick_en), .clear(load),
        .code(cfg.presc), .stick(stick)
    );

    wdg_downcounter u_cnt (
        .clk(clk), .rst(rst), .load(load), .stick(stick),
        .reload(cfg.reload), .cnt(cnt), .expire_now(expire_now),
        .req(wdg_reset_req)
    );

    always_ff @(posedge clk) begin
        if (por)             wdg_reset_flag <= 1'b0;
        else if (expire_now) wdg_reset_flag <= 1'b1;
        else if (clr_flag)   wdg_reset_flag <= 1'b0;
    end

    // R3: no request unless armed
    a_r3_req_needs_running: assert property (@(posedge clk) disable iff (rst)
        wdg_reset_req |-> running);
    // R9: the cause flag accompanies every request
    a_r9_flag_with_req: assert property (@(posedge clk) disable iff (rst || por)
        wdg_reset_req |-> wdg_reset_flag);
    // R8: a frozen halt keeps the count
    a_r8_frozen_holds: assert property (@(posedge clk) disable iff (rst)
        (frozen && !load) |=> $stable(cnt));
endmodule

// File: tb/keyed_watchdog_test.sv
module keyed_watchdog_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1, por = 1'b1;
    logic        lsi_tick = 1'b0, dbg_freeze_en = 1'b0, core_halted = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'h0;
    logic        running, pr_busy, rl_busy, wdg_reset_req, wdg_reset_flag;

    int n_checks = 0, n_fail = 0, tickno = 0, s = 0;
    int exp_q[$];
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    keyed_watchdog uut (
        .clk(clk), .rst(rst), .por(por), .lsi_tick(lsi_tick),
        .dbg_freeze_en(dbg_freeze_en), .core_halted(core_halted),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .running(running), .pr_busy(pr_busy), .rl_busy(rl_busy),
        .wdg_reset_req(wdg_reset_req), .wdg_reset_flag(wdg_reset_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); lsi_tick = 1'b1; tickno++;
            @(negedge clk); lsi_tick = 1'b0;
        end
    endtask

    task automatic sys_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic drained(input string req);
        chk({req, " pending expected resets"}, exp_q.size(), 0);
        exp_q.delete();
    endtask

    // monitor: every request must match the next expected tick index
    always @(negedge clk) begin
        if (!rst && wdg_reset_req) begin
            if (exp_q.size() == 0) chk("R2 unexpected reset at tick", tickno, -1);
            else                   chk("R2 reset tick", tickno, exp_q.pop_front());
        end
    end

    initial begin
        for (int c = 0; c < 190000; c++) @(posedge clk);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog timeout actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0; por = 1'b0;
        @(negedge clk);
        chk("R1 reset running", running, 0);
        chk("R3 reset req", wdg_reset_req, 0);
        chk("R9 reset flag", wdg_reset_flag, 0);
        chk("R7 reset busy", pr_busy | rl_busy, 0);

        // not armed: ticks cause nothing (monitor flags any request)
        ticks(40);

        // R5 defaults: divide 4, reload 4095
        wr(2'd0, 16'hCCCC); s = tickno;
        chk("R1 armed", running, 1);
        exp_q.push_back(s + 4 * 4096);
        ticks(4 * 4096 + 2);
        drained("R5 default timeout");
        sys_reset();

        // R6 closed writes ignored, R7 immediate when stopped, R1 no disarm
        wr(2'd0, 16'h5555);
        wr(2'd2, 16'd3);
        wr(2'd1, 16'd0);
        chk("R7 stopped write no busy", pr_busy | rl_busy, 0);
        wr(2'd0, 16'h1234);
        wr(2'd2, 16'd100);
        wr(2'd0, 16'hCCCC); s = tickno;
        exp_q.push_back(s + 16);
        wr(2'd0, 16'h0000);
        chk("R1 wrong key keeps running", running, 1);
        wr(2'd0, 16'h5555);
        chk("R1 open key keeps running", running, 1);
        ticks(18);
        drained("R6 closed reload ignored");
        chk("R9 flag set", wdg_reset_flag, 1);
        sys_reset();
        chk("R9 flag survives rst", wdg_reset_flag, 1);
        chk("R1 rst disarms", running, 0);
        wr(2'd3, 16'h0000);
        chk("R9 clear bit low", wdg_reset_flag, 1);
        wr(2'd3, 16'h0001);
        chk("R9 cleared", wdg_reset_flag, 0);

        // R4 refresh, divide 8
        wr(2'd0, 16'h5555); wr(2'd2, 16'd3); wr(2'd1, 16'd1);
        wr(2'd0, 16'hCCCC);
        ticks(20);
        wr(2'd0, 16'hAAAA); s = tickno;
        exp_q.push_back(s + 32);
        ticks(34);
        drained("R4 refresh");
        sys_reset();

        // R7 busy while running
        wr(2'd0, 16'h5555); wr(2'd2, 16'd3); wr(2'd1, 16'd0);
        wr(2'd0, 16'hCCCC);
        ticks(3);
        wr(2'd0, 16'h5555);
        wr(2'd2, 16'd1);
        wr(2'd1, 16'd1);
        chk("R7 rl busy", rl_busy, 1);
        chk("R7 pr busy", pr_busy, 1);
        ticks(1);
        chk("R7 rl busy cleared", rl_busy, 0);
        chk("R7 pr busy cleared", pr_busy, 0);
        wr(2'd0, 16'hAAAA); s = tickno;
        exp_q.push_back(s + 16);
        ticks(18);
        drained("R7 new values after tick");
        sys_reset();

        // R8 freeze
        wr(2'd0, 16'h5555); wr(2'd2, 16'd3); wr(2'd1, 16'd0);
        wr(2'd0, 16'hCCCC); s = tickno;
        exp_q.push_back(s + 46);
        core_halted = 1'b1; ticks(3);
        core_halted = 1'b0; ticks(2);
        dbg_freeze_en = 1'b1; core_halted = 1'b1; ticks(30);
        core_halted = 1'b0; ticks(13);
        dbg_freeze_en = 1'b0;
        drained("R8 freeze");
        sys_reset();

        // R5 codes 7 and 6 both divide by 256
        wr(2'd0, 16'h5555); wr(2'd2, 16'd0); wr(2'd1, 16'd7);
        wr(2'd0, 16'hCCCC); s = tickno;
        exp_q.push_back(s + 256);
        ticks(258);
        drained("R5 code 7");
        sys_reset();
        wr(2'd0, 16'h5555); wr(2'd2, 16'd1); wr(2'd1, 16'd6);
        wr(2'd0, 16'hCCCC); s = tickno;
        exp_q.push_back(s + 512);
        ticks(514);
        drained("R5 code 6");
        sys_reset();

        // R10 refresh in the same cycle as the expiring tick
        wr(2'd0, 16'h5555); wr(2'd2, 16'd3); wr(2'd1, 16'd0);
        wr(2'd0, 16'hCCCC);
        ticks(15);
        @(negedge clk);
        lsi_tick = 1'b1; tickno++;
        wr_en = 1'b1; wr_sel = 2'd0; wr_data = 16'hAAAA;
        @(negedge clk);
        lsi_tick = 1'b0; wr_en = 1'b0;
        s = tickno;
        chk("R10 no reset on collision", wdg_reset_req, 0);
        exp_q.push_back(s + 16);
        ticks(17);
        drained("R10 refresh wins");
        sys_reset();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule